// File: doc/BRIEF.md
# Serial Command to AXI-Lite Master Bridge

This block sits behind a byte-oriented serial receiver and turns each fixed 40-bit command into one AXI-Lite master access. The command names a direction, a transfer size of one to four bytes and one of 32 target devices, and carries a 32-bit payload. Each device owns a 64 KiB window, so the device number, shifted left by 16, is the access address. Writes drive the payload with a byte strobe sized by the command. Reads return as many bytes of the read data as the command asked for.

Results go back to the requester on a byte stream with valid/ready flow control. A good write gives one acknowledge byte. A good read gives its data bytes, least significant first. Any failed response gives one error byte. Only one access is in flight at a time. Bytes that arrive while an access is being handled are dropped.

Top module: `pkt_axil_bridge`

## Requirements
- R1: After reset, awvalid_o, wvalid_o, arvalid_o, bready_o, rready_o and tx_valid_o are all low.
- R2: A command is five bytes sent on rx_valid_i/rx_data_i, and the first byte is command bits 39:32. Bit 39 = 1 selects a read and 0 a write. Bits 38:37 hold the byte count minus one. Bits 36:32 hold the device number. Bits 31:0 hold the payload.
- R3: A write raises awvalid_o and wvalid_o together, with awaddr_o = device << 16 and wdata_o = payload. Each valid, with its address or data, stays stable until its own ready is seen.
- R4: wstrb_o follows the size field: 00 -> 0001, 01 -> 0011, 10 -> 0111, 11 -> 1111.
- R5: Once both write handshakes are done, bready_o is raised. A write response of OKAY (00) returns exactly one byte, 0xAA.
- R6: A read raises arvalid_o with araddr_o = device << 16 and holds it until arready_i. An OKAY read response returns size+1 bytes of rdata_i, least significant byte first.
- R7: Any response code other than 00, on the write or the read path, returns exactly one byte, 0xEE, in place of the acknowledge or the data.
- R8: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o stays unchanged.
- R9: Bytes received after the fifth byte of a command, and until the bridge is idle again, are discarded. They do not start or corrupt a later command.
- R10: Only one access is in flight. A read request and a write request are never pending together, and no response byte is offered while a request is still pending on the AXI-Lite side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Command byte strobe |
| rx_data_i | input | 8 | Command byte |
| tx_valid_o | output | 1 | Response byte valid |
| tx_data_o | output | 8 | Response byte |
| tx_ready_i | input | 1 | Response byte accepted |
| awaddr_o | output | 32 | Write address |
| awvalid_o | output | 1 | Write address valid |
| awready_i | input | 1 | Write address ready |
| wdata_o | output | 32 | Write data |
| wstrb_o | output | 4 | Write byte strobe |
| wvalid_o | output | 1 | Write data valid |
| wready_i | input | 1 | Write data ready |
| bresp_i | input | 2 | Write response code |
| bvalid_i | input | 1 | Write response valid |
| bready_o | output | 1 | Write response ready |
| araddr_o | output | 32 | Read address |
| arvalid_o | output | 1 | Read address valid |
| arready_i | input | 1 | Read address ready |
| rdata_i | input | 32 | Read data |
| rresp_i | input | 2 | Read response code |
| rvalid_i | input | 1 | Read data valid |
| rready_o | output | 1 | Read data ready |

## Verification
Writes of all four sizes go to the lowest, middle and highest device numbers. Unequal address and data ready delays show whether each write channel is held on its own, and the strobe value shows whether the size field is decoded or merely passed along. Reads of each size, run with and without backpressure on the response stream, tell a correct byte count and order from a stream that is truncated, reversed or unstable. Error codes on both response paths, and junk bytes sent right after a command, show whether failures give a single error byte and whether the assembler stays shut while busy.

// File: rtl/pab_pkg.sv
`timescale 1ns/1ps
package pab_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_WAIT_B,
    ST_RD,
    ST_WAIT_R,
    ST_SEND
  } bridge_state_e;

  localparam logic [7:0] ACK_OK  = 8'hAA;
  localparam logic [7:0] ACK_ERR = 8'hEE;
  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/pab_pkt_assembler.sv
`timescale 1ns/1ps
module pab_pkt_assembler #(
  parameter int unsigned PKT_BYTES = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   byte_valid_i,
  input  logic [7:0]             byte_i,
  output logic                   pkt_valid_o,
  output logic [PKT_BYTES*8-1:0] pkt_o
);
  localparam int unsigned PKT_W = PKT_BYTES * 8;
  localparam int unsigned CNT_W = $clog2(PKT_BYTES);

  logic [CNT_W-1:0] cnt_q;
  logic [PKT_W-1:0] sh_q;
  logic             pv_q;
  logic             take, last;

  assign take = en_i & byte_valid_i;
  assign last = (cnt_q == CNT_W'(PKT_BYTES - 1));

  // first byte ends up in the top byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
      pv_q  <= 1'b0;
    end else begin
      pv_q <= take & last;
      if (take) begin
        sh_q  <= {sh_q[PKT_W-9:0], byte_i};
        cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
      end
    end
  end

  assign pkt_valid_o = pv_q;
  assign pkt_o       = sh_q;
endmodule

// File: rtl/pab_resp_serializer.sv
`timescale 1ns/1ps
module pab_resp_serializer #(
  parameter int unsigned MAX_BYTES = 4,
  localparam int unsigned CNT_W = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [MAX_BYTES*8-1:0] load_data_i,
  input  logic [CNT_W-1:0]       load_cnt_i,
  output logic                   tx_valid_o,
  output logic [7:0]             tx_data_o,
  input  logic                   tx_ready_i
);
  logic [MAX_BYTES*8-1:0] buf_q;
  logic [CNT_W-1:0]       left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      left_q <= '0;
    end else if (load_i) begin
      buf_q  <= load_data_i;
      left_q <= load_cnt_i;
    end else if (tx_valid_o && tx_ready_i) begin
      buf_q  <= buf_q >> 8;
      left_q <= left_q - CNT_W'(1);
    end
  end

  assign tx_valid_o = (left_q != '0);
  assign tx_data_o  = buf_q[7:0];
endmodule

// File: rtl/pkt_axil_bridge.sv
`timescale 1ns/1ps
module pkt_axil_bridge
  import pab_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DEV_W     = 5,
  parameter int unsigned SIZE_W    = 2,
  parameter int unsigned WIN_SHIFT = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_valid_i,
  input  logic [7:0]          rx_data_i,
  output logic                tx_valid_o,
  output logic [7:0]          tx_data_o,
  input  logic                tx_ready_i,
  output logic [ADDR_W-1:0]   awaddr_o,
  output logic                awvalid_o,
  input  logic                awready_i,
  output logic [DATA_W-1:0]   wdata_o,
  output logic [DATA_W/8-1:0] wstrb_o,
  output logic                wvalid_o,
  input  logic                wready_i,
  input  logic [1:0]          bresp_i,
  input  logic                bvalid_i,
  output logic                bready_o,
  output logic [ADDR_W-1:0]   araddr_o,
  output logic                arvalid_o,
  input  logic                arready_i,
  input  logic [DATA_W-1:0]   rdata_i,
  input  logic [1:0]          rresp_i,
  input  logic                rvalid_i,
  output logic                rready_o
);
  localparam int unsigned STRB_W    = DATA_W / 8;
  localparam int unsigned PKT_W     = 1 + SIZE_W + DEV_W + DATA_W;
  localparam int unsigned PKT_BYTES = PKT_W / 8;
  localparam int unsigned CNT_W     = $clog2(STRB_W + 1);

  bridge_state_e     state_q;
  logic [SIZE_W-1:0] size_q;
  logic [DEV_W-1:0]  dev_q;
  logic [DATA_W-1:0] data_q;
  logic              awvalid_q, wvalid_q, arvalid_q;

  logic              pkt_valid;
  logic [PKT_W-1:0]  pkt;
  logic              asm_en;
  logic              ld;
  logic [DATA_W-1:0] ld_data;
  logic [CNT_W-1:0]  ld_cnt;
  logic              aw_left, w_left;

  // closed while a command is being served, including its capture cycle
  assign asm_en = (state_q == ST_IDLE) && !pkt_valid;

  pab_pkt_assembler #(.PKT_BYTES(PKT_BYTES)) u_asm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (asm_en),
    .byte_valid_i(rx_valid_i),
    .byte_i      (rx_data_i),
    .pkt_valid_o (pkt_valid),
    .pkt_o       (pkt)
  );

  pab_resp_serializer #(.MAX_BYTES(STRB_W)) u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld),
    .load_data_i(ld_data),
    .load_cnt_i (ld_cnt),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .tx_ready_i (tx_ready_i)
  );

  assign aw_left = awvalid_q && !awready_i;
  assign w_left  = wvalid_q && !wready_i;

  always_comb begin
    ld      = 1'b0;
    ld_data = {{(DATA_W-8){1'b0}}, ACK_ERR};
    ld_cnt  = CNT_W'(1);
    if (state_q == ST_WAIT_B && bvalid_i) begin
      ld = 1'b1;
      if (bresp_i == RESP_OKAY) ld_data = {{(DATA_W-8){1'b0}}, ACK_OK};
    end else if (state_q == ST_WAIT_R && rvalid_i) begin
      ld = 1'b1;
      if (rresp_i == RESP_OKAY) begin
        ld_data = rdata_i;
        ld_cnt  = CNT_W'(size_q) + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      size_q    <= '0;
      dev_q     <= '0;
      data_q    <= '0;
      awvalid_q <= 1'b0;
      wvalid_q  <= 1'b0;
      arvalid_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (pkt_valid) begin
          size_q <= pkt[PKT_W-2 -: SIZE_W];
          dev_q  <= pkt[DATA_W+DEV_W-1 -: DEV_W];
          data_q <= pkt[DATA_W-1:0];
          if (pkt[PKT_W-1]) begin
            arvalid_q <= 1'b1;
            state_q   <= ST_RD;
          end else begin
            awvalid_q <= 1'b1;
            wvalid_q  <= 1'b1;
            state_q   <= ST_WR;
          end
        end
        ST_WR: begin
          if (awready_i) awvalid_q <= 1'b0;
          if (wready_i)  wvalid_q  <= 1'b0;
          if (!aw_left && !w_left) state_q <= ST_WAIT_B;
        end
        ST_WAIT_B: if (bvalid_i) state_q <= ST_SEND;
        ST_RD: if (arready_i) begin
          arvalid_q <= 1'b0;
          state_q   <= ST_WAIT_R;
        end
        ST_WAIT_R: if (rvalid_i) state_q <= ST_SEND;
        ST_SEND: if (!tx_valid_o) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < STRB_W; g++) begin : g_strb
    assign wstrb_o[g] = (32'(g) <= 32'(size_q));
  end

  assign awaddr_o  = ADDR_W'(dev_q) << WIN_SHIFT;
  assign araddr_o  = ADDR_W'(dev_q) << WIN_SHIFT;
  assign wdata_o   = data_q;
  assign awvalid_o = awvalid_q;
  assign wvalid_o  = wvalid_q;
  assign arvalid_o = arvalid_q;
  assign bready_o  = (state_q == ST_WAIT_B);
  assign rready_o  = (state_q == ST_WAIT_R);
endmodule

// File: rtl/pab_bridge_checker.sv
`timescale 1ns/1ps
module pab_bridge_checker #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned WIN_SHIFT = 16,
  localparam int unsigned STRB_W   = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              awvalid_o,
  input logic              awready_i,
  input logic [ADDR_W-1:0] awaddr_o,
  input logic              wvalid_o,
  input logic              wready_i,
  input logic [DATA_W-1:0] wdata_o,
  input logic [STRB_W-1:0] wstrb_o,
  input logic              arvalid_o,
  input logic              arready_i,
  input logic [ADDR_W-1:0] araddr_o,
  input logic              bready_o,
  input logic              rready_o,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [7:0]        tx_data_o
);
  assert_aw_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awvalid_o && !awready_i |=> awvalid_o && $stable(awaddr_o));

  assert_w_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wvalid_o && !wready_i |=> wvalid_o && $stable(wdata_o) && $stable(wstrb_o));

  assert_aw_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awvalid_o |-> awaddr_o[WIN_SHIFT-1:0] == '0);

  assert_strb_shape_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wvalid_o |-> wstrb_o[0] && ((wstrb_o & (wstrb_o + STRB_W'(1))) == '0));

  assert_ar_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arvalid_o && !arready_i |=> arvalid_o && $stable(araddr_o));

  assert_ar_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arvalid_o |-> araddr_o[WIN_SHIFT-1:0] == '0);

  assert_tx_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  assert_one_dir_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arvalid_o |-> !awvalid_o && !wvalid_o);

  assert_quiet_tx_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awvalid_o || wvalid_o || arvalid_o || bready_o || rready_o) |-> !tx_valid_o);
endmodule

bind pkt_axil_bridge pab_bridge_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_SHIFT(WIN_SHIFT)
) u_chk (.*);

// File: tb/pkt_axil_bridge_test.sv
`timescale 1ns/1ps
module pkt_axil_bridge_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        tx_valid_o, tx_ready_i;
  logic [7:0]  tx_data_o;
  logic [31:0] awaddr_o, wdata_o, araddr_o, rdata_i;
  logic [3:0]  wstrb_o;
  logic        awvalid_o, awready_i, wvalid_o, wready_i, bvalid_i, bready_o;
  logic        arvalid_o, arready_i, rvalid_i, rready_o;
  logic [1:0]  bresp_i, rresp_i;

  pkt_axil_bridge uut (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i),
    .awaddr_o(awaddr_o), .awvalid_o(awvalid_o), .awready_i(awready_i),
    .wdata_o(wdata_o), .wstrb_o(wstrb_o), .wvalid_o(wvalid_o), .wready_i(wready_i),
    .bresp_i(bresp_i), .bvalid_i(bvalid_i), .bready_o(bready_o),
    .araddr_o(araddr_o), .arvalid_o(arvalid_o), .arready_i(arready_i),
    .rdata_i(rdata_i), .rresp_i(rresp_i), .rvalid_i(rvalid_i), .rready_o(rready_o)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model state
  logic [7:0]  exp_q[$];
  bit          exp_rd;
  logic [31:0] exp_addr, exp_data, cfg_rdata;
  logic [3:0]  exp_strb;
  logic [1:0]  cfg_resp;
  int          aw_lat, w_lat, ar_lat;
  int          aw_wait, w_wait, ar_wait;
  bit          aw_seen, w_seen, ar_seen, b_done, r_done, b_drop, r_drop;
  bit          bp_mode;
  string       cur_tag = "R1";
  int          cyc = 0;
  bit          txv_prev, txr_prev;
  logic [7:0]  txd_prev;
  logic [7:0]  e;

  // slave and response-stream model, evaluated away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      awready_i = 0; wready_i = 0; arready_i = 0;
      bvalid_i = 0; rvalid_i = 0; bresp_i = 0; rresp_i = 0; rdata_i = 0;
      tx_ready_i = 0; txv_prev = 0; txr_prev = 0; txd_prev = 0;
    end else begin
      if (awvalid_o && !aw_seen) begin
        if (aw_wait >= aw_lat) begin
          awready_i = 1; aw_seen = 1; aw_wait = 0;
          chk(!exp_rd, "R10", "write address on a read", 1, 0);
          chk(awaddr_o == exp_addr, "R3", "awaddr", awaddr_o, exp_addr);
        end else begin awready_i = 0; aw_wait++; end
      end else awready_i = 0;

      if (wvalid_o && !w_seen) begin
        if (w_wait >= w_lat) begin
          wready_i = 1; w_seen = 1; w_wait = 0;
          chk(wdata_o == exp_data, "R3", "wdata", wdata_o, exp_data);
          chk(wstrb_o == exp_strb, "R4", "wstrb", wstrb_o, exp_strb);
        end else begin wready_i = 0; w_wait++; end
      end else wready_i = 0;

      if (arvalid_o && !ar_seen) begin
        if (ar_wait >= ar_lat) begin
          arready_i = 1; ar_seen = 1; ar_wait = 0;
          chk(exp_rd, "R10", "read address on a write", 1, 0);
          chk(araddr_o == exp_addr, "R6", "araddr", araddr_o, exp_addr);
        end else begin arready_i = 0; ar_wait++; end
      end else arready_i = 0;

      if (b_drop) begin bvalid_i = 0; b_drop = 0; end
      else if (aw_seen && w_seen && !b_done && !bvalid_i) begin bvalid_i = 1; bresp_i = cfg_resp; end
      if (bvalid_i && bready_o) begin b_drop = 1; b_done = 1; end

      if (r_drop) begin rvalid_i = 0; r_drop = 0; end
      else if (ar_seen && !r_done && !rvalid_i) begin
        rvalid_i = 1; rresp_i = cfg_resp; rdata_i = cfg_rdata;
      end
      if (rvalid_i && rready_o) begin r_drop = 1; r_done = 1; end

      if (txv_prev && !txr_prev)
        chk(tx_valid_o && tx_data_o == txd_prev, "R8", "held byte", tx_data_o, txd_prev);
      if ((awvalid_o || wvalid_o || arvalid_o) && tx_valid_o)
        chk(0, "R10", "byte offered with request pending", 1, 0);
      tx_ready_i = bp_mode ? (cyc % 3 == 2) : 1'b1;
      if (tx_valid_o && tx_ready_i) begin
        if (exp_q.size() == 0) chk(0, "R9", "unexpected response byte", tx_data_o, 0);
        else begin
          e = exp_q.pop_front();
          chk(tx_data_o == e, cur_tag, "response byte", tx_data_o, e);
        end
      end
      txv_prev = tx_valid_o; txr_prev = tx_ready_i; txd_prev = tx_data_o;
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid_i = 1'b1;
    rx_data_i  = b;
    @(negedge clk);
    rx_valid_i = 1'b0;
  endtask

  task automatic do_cmd(input bit rd, input logic [1:0] sz, input logic [4:0] dev,
                        input logic [31:0] pl, input logic [1:0] resp,
                        input logic [31:0] rdat, input int lat, input bit junk,
                        input string tag);
    logic [39:0] pkt;
    int t;
    pkt = {rd, sz, dev, pl};
    cur_tag = tag;
    aw_seen = 0; w_seen = 0; ar_seen = 0; b_done = 0; r_done = 0;
    aw_wait = 0; w_wait = 0; ar_wait = 0;
    aw_lat = lat; w_lat = (lat * 2) % 5; ar_lat = lat;
    exp_rd = rd; exp_addr = 32'(dev) << 16; exp_data = pl;
    exp_strb = 4'((1 << (int'(sz) + 1)) - 1);
    cfg_resp = resp; cfg_rdata = rdat;
    if (resp != 2'b00) exp_q.push_back(8'hEE);
    else if (!rd) exp_q.push_back(8'hAA);
    else for (int i = 0; i <= int'(sz); i++) exp_q.push_back(rdat[8*i +: 8]);
    for (int i = 0; i < 5; i++) send_byte(pkt[39-8*i -: 8]);
    if (junk) for (int i = 0; i < 3; i++) send_byte(8'hF0 | 8'(i));
    t = 0;
    while (exp_q.size() != 0 && t < 500) begin @(negedge clk); t++; end
    chk(exp_q.size() == 0, tag, "missing response bytes", exp_q.size(), 0);
    exp_q.delete();
    repeat (4) @(negedge clk);
    if (rd) chk(ar_seen && r_done, tag, "read flow complete", {ar_seen, r_done}, 2'b11);
    else    chk(aw_seen && w_seen && b_done, tag, "write flow complete",
                {aw_seen, w_seen, b_done}, 3'b111);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bp_mode = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet outputs after reset
    chk(!awvalid_o && !wvalid_o && !arvalid_o, "R1", "request valids", {awvalid_o, wvalid_o, arvalid_o}, 0);
    chk(!bready_o && !rready_o, "R1", "response readies", {bready_o, rready_o}, 0);
    chk(!tx_valid_o, "R1", "tx_valid", tx_valid_o, 0);

    // R2 R3 R4 R5 writes of each size and device range
    do_cmd(0, 2'b11, 5'h05, 32'hDEADBEEF, 2'b00, 0, 0, 0, "R5");
    do_cmd(0, 2'b00, 5'h1F, 32'h000000A5, 2'b00, 0, 2, 0, "R4");
    do_cmd(0, 2'b01, 5'h00, 32'h00001234, 2'b00, 0, 3, 0, "R2");
    bp_mode = 1;
    do_cmd(0, 2'b10, 5'h10, 32'h00ABCDEF, 2'b00, 0, 1, 0, "R3");
    // R6 reads with and without backpressure
    bp_mode = 0;
    do_cmd(1, 2'b11, 5'h03, 32'h0, 2'b00, 32'h11223344, 0, 0, "R6");
    bp_mode = 1;
    do_cmd(1, 2'b00, 5'h1E, 32'h0, 2'b00, 32'hCAFEF00D, 1, 0, "R8");
    do_cmd(1, 2'b10, 5'h07, 32'h0, 2'b00, 32'h89ABCDEF, 2, 0, "R6");
    do_cmd(1, 2'b01, 5'h01, 32'h0, 2'b00, 32'h0000BEAD, 0, 0, "R2");
    // R7 error responses
    bp_mode = 0;
    do_cmd(0, 2'b11, 5'h02, 32'h55AA55AA, 2'b10, 0, 0, 0, "R7");
    do_cmd(1, 2'b11, 5'h04, 32'h0, 2'b11, 32'h01020304, 1, 0, "R7");
    do_cmd(1, 2'b01, 5'h08, 32'h0, 2'b01, 32'h0000FFFF, 0, 0, "R7");
    // R9 junk after a command, then clean commands
    do_cmd(0, 2'b01, 5'h09, 32'h0000C0DE, 2'b00, 0, 4, 1, "R9");
    do_cmd(1, 2'b11, 5'h0A, 32'h0, 2'b00, 32'hA1B2C3D4, 2, 1, "R9");
    do_cmd(0, 2'b00, 5'h0B, 32'h00000077, 2'b00, 0, 0, 0, "R9");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule